// File: doc/BRIEF.md
# Cartridge GPIO Port Overlay

This block places a four-pin general-purpose I/O port on top of three halfword locations inside a read-only memory window. A bus master writes a pin-direction register, an output-data register and a read-back control register. The pins go out to an external serial device, such as a real-time clock, as separate input, output and output-enable signals. The block stores nothing from the memory itself: the memory word for the current read address arrives on an input, and the block either passes it through or replaces it with port state.

The direction register serves as both the write mask and the read mask. Pins marked as outputs take their levels from data writes. Pins marked as inputs are the only ones visible on data reads. One control bit decides whether the three port locations can be read at all. While it is clear, the port can only be written, and every read returns memory data. Reads are combinational from the read address. Writes take effect at the next rising clock edge.

Top module: `cart_gpio_overlay`

## Requirements
- R1: While reset is asserted and right after it, direction, output data and read-back enable are all zero. pin_oe and pin_out are 0, and a read at any address returns rom_data.
- R2: A write to offset 0xC6 stores wr_data[3:0] as the direction (1 = output, 0 = input). From the next clock edge pin_oe equals the stored direction.
- R3: A write to offset 0xC4 stores wr_data[3:0] AND direction. pin_out shows the stored value from the next edge and keeps it when the direction changes later.
- R4: With read-back enabled, a read at 0xC4 returns pin_in AND NOT direction in bits 3:0, and zero in bits 15:4.
- R5: With read-back enabled, a read at 0xC6 returns the direction in bits 3:0. A read at 0xC8 returns the enable in bit 0. All other bits read as zero.
- R6: A write to 0xC8 sets read-back enable from wr_data[0] and ignores the other bits. While the enable is 0, reads at 0xC4, 0xC6 and 0xC8 return rom_data. The enable has no effect on pin_out or pin_oe.
- R7: A read at any address other than the three port offsets returns rom_data, even while read-back is enabled.
- R8: A read in the same cycle as a write shows the register state from before that write.
- R9: A write to any address other than the three port offsets changes no register.
- R10: Address bit 0 is ignored for both reads and writes. For example, 0xC5 selects the data register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Write strobe, sampled at the rising edge |
| wr_addr | input | 8 | Byte offset of the write inside the window |
| wr_data | input | 16 | Write halfword |
| rd_addr | input | 8 | Byte offset of the current read |
| rom_data | input | 16 | Memory word for rd_addr |
| rd_data | output | 16 | Read result, port state or rom_data |
| pin_in | input | 4 | Levels sampled from the pins |
| pin_out | output | 4 | Levels driven onto the pins |
| pin_oe | output | 4 | Per-pin output enable |

## Verification
Two operations can meet in one cycle: a register write at the clock edge and a combinational read of the same or a related register. The bench provokes this in several ways:

- a direction write during a data read;
- a control write during a control read;
- a data write during a direction read.

In each case the read result in that cycle is judged against the state from before the write. The pin outputs sampled after the edge are judged against the state after it.

// File: rtl/gpo_pkg.sv
package gpo_pkg;
    localparam int HALF_W = 16;

    typedef enum logic [1:0] {
        SEL_NONE = 2'd0,
        SEL_DATA = 2'd1,
        SEL_DIR  = 2'd2,
        SEL_CTRL = 2'd3
    } gpo_sel_e;
endpackage

// File: rtl/gpo_decode.sv
module gpo_decode
    import gpo_pkg::*;
#(
    parameter int               ADDR_W   = 8,
    parameter logic [ADDR_W-1:0] OFF_DATA = 8'hC4,
    parameter logic [ADDR_W-1:0] OFF_DIR  = 8'hC6,
    parameter logic [ADDR_W-1:0] OFF_CTRL = 8'hC8
) (
    input  logic [ADDR_W-1:0] addr,
    output gpo_sel_e          sel
);
    // halfword granularity: the lowest address bit plays no part
    logic [ADDR_W-2:0] hw_addr;
    assign hw_addr = addr[ADDR_W-1:1];

    always_comb begin
        if (hw_addr == OFF_DATA[ADDR_W-1:1]) begin
            sel = SEL_DATA;
        end else if (hw_addr == OFF_DIR[ADDR_W-1:1]) begin
            sel = SEL_DIR;
        end else if (hw_addr == OFF_CTRL[ADDR_W-1:1]) begin
            sel = SEL_CTRL;
        end else begin
            sel = SEL_NONE;
        end
    end
endmodule

// File: rtl/gpo_regfile.sv
module gpo_regfile
    import gpo_pkg::*;
#(
    parameter int PINS = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  gpo_sel_e          wr_sel,
    input  logic [HALF_W-1:0] wr_data,
    output logic [PINS-1:0]   data_q,
    output logic [PINS-1:0]   dir_q,
    output logic              rdback_q
);
    typedef struct packed {
        logic [PINS-1:0] data;
        logic [PINS-1:0] dir;
        logic            rdback;
    } state_t;

    state_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (wr_en) begin
            unique case (wr_sel)
                SEL_DATA: st_d.data   = wr_data[PINS-1:0] & st_q.dir;
                SEL_DIR:  st_d.dir    = wr_data[PINS-1:0];
                SEL_CTRL: st_d.rdback = wr_data[0];
                default:  st_d        = st_q;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign data_q   = st_q.data;
    assign dir_q    = st_q.dir;
    assign rdback_q = st_q.rdback;
endmodule

// File: rtl/gpo_readmux.sv
module gpo_readmux
    import gpo_pkg::*;
#(
    parameter int PINS = 4
) (
    input  gpo_sel_e          rd_sel,
    input  logic              rdback,
    input  logic [PINS-1:0]   dir,
    input  logic [PINS-1:0]   pin_in,
    input  logic [HALF_W-1:0] rom_data,
    output logic [HALF_W-1:0] rd_data
);
    localparam int PAD_W = HALF_W - PINS;

    always_comb begin
        rd_data = rom_data;
        if (rdback) begin
            unique case (rd_sel)
                SEL_DATA: rd_data = {{PAD_W{1'b0}}, pin_in & ~dir};
                SEL_DIR:  rd_data = {{PAD_W{1'b0}}, dir};
                SEL_CTRL: rd_data = {{(HALF_W-1){1'b0}}, rdback};
                default:  rd_data = rom_data;
            endcase
        end
    end
endmodule

// File: rtl/cart_gpio_overlay.sv
module cart_gpio_overlay
    import gpo_pkg::*;
#(
    parameter int                ADDR_W   = 8,
    parameter int                PINS     = 4,
    parameter logic [ADDR_W-1:0] OFF_DATA = 8'hC4,
    parameter logic [ADDR_W-1:0] OFF_DIR  = 8'hC6,
    parameter logic [ADDR_W-1:0] OFF_CTRL = 8'hC8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [HALF_W-1:0] wr_data,
    input  logic [ADDR_W-1:0] rd_addr,
    input  logic [HALF_W-1:0] rom_data,
    output logic [HALF_W-1:0] rd_data,
    input  logic [PINS-1:0]   pin_in,
    output logic [PINS-1:0]   pin_out,
    output logic [PINS-1:0]   pin_oe
);
    gpo_sel_e        wr_sel, rd_sel;
    logic [PINS-1:0] data_q, dir_q;
    logic            rdback_q;

    gpo_decode #(
        .ADDR_W(ADDR_W), .OFF_DATA(OFF_DATA), .OFF_DIR(OFF_DIR), .OFF_CTRL(OFF_CTRL)
    ) u_wr_dec (
        .addr(wr_addr),
        .sel (wr_sel)
    );

    gpo_decode #(
        .ADDR_W(ADDR_W), .OFF_DATA(OFF_DATA), .OFF_DIR(OFF_DIR), .OFF_CTRL(OFF_CTRL)
    ) u_rd_dec (
        .addr(rd_addr),
        .sel (rd_sel)
    );

    gpo_regfile #(.PINS(PINS)) u_regs (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (wr_en),
        .wr_sel  (wr_sel),
        .wr_data (wr_data),
        .data_q  (data_q),
        .dir_q   (dir_q),
        .rdback_q(rdback_q)
    );

    gpo_readmux #(.PINS(PINS)) u_rmux (
        .rd_sel  (rd_sel),
        .rdback  (rdback_q),
        .dir     (dir_q),
        .pin_in  (pin_in),
        .rom_data(rom_data),
        .rd_data (rd_data)
    );

    assign pin_out = data_q;
    assign pin_oe  = dir_q;
endmodule

// File: rtl/gpo_checker.sv
module gpo_checker #(
    parameter int                ADDR_W   = 8,
    parameter int                PINS     = 4,
    parameter logic [ADDR_W-1:0] OFF_DATA = 8'hC4,
    parameter logic [ADDR_W-1:0] OFF_DIR  = 8'hC6,
    parameter logic [ADDR_W-1:0] OFF_CTRL = 8'hC8
) (
    input logic              clk,
    input logic              rst_n,
    input logic              wr_en,
    input logic [ADDR_W-1:0] wr_addr,
    input logic [15:0]       wr_data,
    input logic [ADDR_W-1:0] rd_addr,
    input logic [15:0]       rom_data,
    input logic [15:0]       rd_data,
    input logic [PINS-1:0]   pin_out,
    input logic [PINS-1:0]   pin_oe,
    input logic              rdback
);
    logic w_data, w_dir, w_ctrl, r_port;
    assign w_data = wr_en && (wr_addr[ADDR_W-1:1] == OFF_DATA[ADDR_W-1:1]);
    assign w_dir  = wr_en && (wr_addr[ADDR_W-1:1] == OFF_DIR[ADDR_W-1:1]);
    assign w_ctrl = wr_en && (wr_addr[ADDR_W-1:1] == OFF_CTRL[ADDR_W-1:1]);
    assign r_port = (rd_addr[ADDR_W-1:1] == OFF_DATA[ADDR_W-1:1]) ||
                    (rd_addr[ADDR_W-1:1] == OFF_DIR[ADDR_W-1:1])  ||
                    (rd_addr[ADDR_W-1:1] == OFF_CTRL[ADDR_W-1:1]);

    AST_DIR_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
        w_dir |=> pin_oe == $past(wr_data[PINS-1:0])); // R2

    AST_DATA_MASKED: assert property (@(posedge clk) disable iff (!rst_n)
        w_data |=> pin_out == ($past(wr_data[PINS-1:0]) & $past(pin_oe))); // R3

    AST_PINS_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !(w_data || w_dir) |=> $stable(pin_out) && $stable(pin_oe)); // R9

    AST_ROM_PASS: assert property (@(posedge clk) disable iff (!rst_n)
        (!r_port || !rdback) |-> rd_data == rom_data); // R7

    AST_UPPER_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (r_port && rdback) |-> rd_data[15:PINS] == '0); // R5

    AST_CTRL_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
        w_ctrl |=> rdback == $past(wr_data[0])); // R6
endmodule

bind cart_gpio_overlay gpo_checker #(
    .ADDR_W(ADDR_W), .PINS(PINS), .OFF_DATA(OFF_DATA), .OFF_DIR(OFF_DIR), .OFF_CTRL(OFF_CTRL)
) u_gpo_checker (
    .clk     (clk),
    .rst_n   (rst_n),
    .wr_en   (wr_en),
    .wr_addr (wr_addr),
    .wr_data (wr_data),
    .rd_addr (rd_addr),
    .rom_data(rom_data),
    .rd_data (rd_data),
    .pin_out (pin_out),
    .pin_oe  (pin_oe),
    .rdback  (rdback_q)
);

// File: tb/cart_gpio_overlay_bench.sv
module cart_gpio_overlay_bench;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_en = 1'b0;
    logic [7:0]  wr_addr = '0;
    logic [15:0] wr_data = '0;
    logic [7:0]  rd_addr = '0;
    logic [15:0] rom_data = '0;
    logic [15:0] rd_data;
    logic [3:0]  pin_in = '0;
    logic [3:0]  pin_out, pin_oe;

    int n_cmp = 0;
    int n_bad = 0;

    always #10 clk = ~clk;

    cart_gpio_overlay u_cart_gpio_overlay (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
        .rd_addr(rd_addr), .rom_data(rom_data), .rd_data(rd_data),
        .pin_in(pin_in), .pin_out(pin_out), .pin_oe(pin_oe)
    );

    typedef struct packed {
        logic        we;
        logic [7:0]  wa;
        logic [15:0] wd;
        logic [7:0]  ra;
        logic [15:0] rom;
        logic [3:0]  pin;
        logic [15:0] exp_rd;
        logic [3:0]  exp_oe;
        logic [3:0]  exp_out;
        logic [7:0]  req;
    } vec_t;

    localparam int NV = 14;
    localparam vec_t VEC [NV] = '{
        '{1'b1, 8'hC8, 16'h0001, 8'hC6, 16'h1111, 4'h0, 16'h1111, 4'h0, 4'h0, 8'd6},  // R6 disabled read
        '{1'b1, 8'hC6, 16'h00F3, 8'hC8, 16'h2222, 4'h0, 16'h0001, 4'h3, 4'h0, 8'd5},  // R5 ctrl read, R2
        '{1'b1, 8'hC4, 16'hFFFF, 8'hC6, 16'h2222, 4'h0, 16'h0003, 4'h3, 4'h3, 8'd3},  // R3 masked store
        '{1'b0, 8'h00, 16'h0000, 8'hC4, 16'h2222, 4'hF, 16'h000C, 4'h3, 4'h3, 8'd4},  // R4 input mask
        '{1'b1, 8'hC6, 16'h000C, 8'hC4, 16'h2222, 4'h5, 16'h0004, 4'hC, 4'h3, 8'd8},  // R8 pre-write read
        '{1'b0, 8'h00, 16'h0000, 8'hC4, 16'h2222, 4'h5, 16'h0001, 4'hC, 4'h3, 8'd4},  // R4 new mask
        '{1'b1, 8'hC4, 16'h000A, 8'hC0, 16'h3333, 4'h0, 16'h3333, 4'hC, 4'h8, 8'd7},  // R7 other addr
        '{1'b1, 8'hC5, 16'h0004, 8'hC5, 16'h3333, 4'hF, 16'h0003, 4'hC, 4'h4, 8'd10}, // R10 odd addr
        '{1'b1, 8'hCA, 16'hFFFF, 8'hC6, 16'h3333, 4'h0, 16'h000C, 4'hC, 4'h4, 8'd9},  // R9 ignored write
        '{1'b1, 8'hC8, 16'h0000, 8'hC8, 16'h3333, 4'h0, 16'h0001, 4'hC, 4'h4, 8'd8},  // R8 ctrl same cycle
        '{1'b0, 8'h00, 16'h0000, 8'hC4, 16'h4444, 4'hF, 16'h4444, 4'hC, 4'h4, 8'd6},  // R6 data hidden
        '{1'b0, 8'h00, 16'h0000, 8'hC6, 16'h5555, 4'h0, 16'h5555, 4'hC, 4'h4, 8'd6},  // R6 dir hidden
        '{1'b1, 8'hC8, 16'hFFFE, 8'hC8, 16'h6666, 4'h0, 16'h6666, 4'hC, 4'h4, 8'd6},  // R6 bit0 only
        '{1'b0, 8'h00, 16'h0000, 8'hC8, 16'h7777, 4'h0, 16'h7777, 4'hC, 4'h4, 8'd6}   // R6 stays off
    };

    task automatic check(input string what, input int req, input logic [15:0] act,
                         input logic [15:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL R%0d %s: actual %h expected %h", req, what, act, exp);
        end
    endtask

    initial begin
        fork
            begin
                #(20 * 50000);
                n_bad++;
                $display("FAIL R0 watchdog: actual timeout expected completion");
                $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
                $finish;
            end
        join_none

        // R1: state during reset
        rd_addr = 8'hC6; rom_data = 16'hABCD;
        #5;
        check("reset rd", 1, rd_data, 16'hABCD);
        check("reset oe", 1, {12'h0, pin_oe}, 16'h0);
        check("reset out", 1, {12'h0, pin_out}, 16'h0);
        @(negedge clk); @(negedge clk);
        rst_n = 1'b1;

        for (int i = 0; i < NV; i++) begin
            @(negedge clk);
            wr_en = VEC[i].we; wr_addr = VEC[i].wa; wr_data = VEC[i].wd;
            rd_addr = VEC[i].ra; rom_data = VEC[i].rom; pin_in = VEC[i].pin;
            #2;
            check("rd_data", int'(VEC[i].req), rd_data, VEC[i].exp_rd);
            @(posedge clk);
            #2;
            wr_en = 1'b0;
            check("pin_oe", int'(VEC[i].req), {12'h0, pin_oe}, {12'h0, VEC[i].exp_oe});
            check("pin_out", int'(VEC[i].req), {12'h0, pin_out}, {12'h0, VEC[i].exp_out});
        end

        // R1: reset mid-run clears everything again
        @(negedge clk);
        rst_n = 1'b0;
        rd_addr = 8'hC8; rom_data = 16'h9999;
        #2;
        check("re-reset oe", 1, {12'h0, pin_oe}, 16'h0);
        check("re-reset out", 1, {12'h0, pin_out}, 16'h0);
        check("re-reset rd", 1, rd_data, 16'h9999);
        @(negedge clk);
        rst_n = 1'b1;
        wr_en = 1'b1; wr_addr = 8'hC8; wr_data = 16'h0001;
        @(negedge clk);
        wr_en = 1'b0;
        rd_addr = 8'hC6; rom_data = 16'h8888;
        #2;
        check("dir after reset", 1, rd_data, 16'h0000);          // R1
        // R4: all pins inputs, full pin value visible
        rd_addr = 8'hC4; pin_in = 4'hA;
        #2;
        check("all inputs read", 4, rd_data, 16'h000A);          // R4
        // R3: data write while all pins are inputs stores nothing
        wr_en = 1'b1; wr_addr = 8'hC4; wr_data = 16'h000F;
        @(posedge clk); #2;
        wr_en = 1'b0;
        check("write with no outputs", 3, {12'h0, pin_out}, 16'h0); // R3

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end
endmodule